// File: doc/BRIEF.md
# Self-Test Session Status and Test-Clock Selector

This block runs one self-test session at a time inside a serial link receiver. While the test-enable input is high, a session is active. The block counts the frames that an upstream frame checker flags as errored, and it drives a live status output that a scope or an external counter can watch. The block also produces a code that tells the clock multiplexer which test clock to use. That code comes from two strap pins by default. When a control bit is set, it comes from a register field instead. The pattern generator, the pattern checker, the oscillator and the clock mux all sit outside this block.

The block runs on a clock at twice the pixel rate, so one clock cycle here is half a pixel-clock period.

The status output idles high. Each errored frame produces one low pulse, one cycle wide, and consecutive errored frames give pulses that are separated from each other. When the session ends, the output shows the pass/fail verdict for one pixel period, which is two cycles. The error count saturates and can be read by a host through a small register port. The count is held until the next session starts or the block is reset.

Top module: `bist_status_ctrl`

## Requirements
- R1: After reset, `pass_o` is 1, the error count reads 0, the configuration-error flag reads 0, and the control register reads 0, which selects pin mode.
- R2: In pin mode (control bit 0 = 0), `sel_pins` selects `clk_src` as follows: 00 gives 0 (pixel clock), 01 gives 3 (50 MHz), and 10 gives 5 (25 MHz).
- R3: In register mode (control bit 0 = 1), the select field is control bits [2:1] and the word mode is control bits [4:3], where 0 = 10-bit, 1 = 12-bit high-frequency and 2 = 12-bit low-frequency. The source codes are 0 = pixel clock, 1 = 100, 2 = 75, 3 = 50, 4 = 37.5 and 5 = 25 MHz. Field 00 gives 0 in every word mode. Field 01 gives 1, 2 or 3 for word modes 0, 1 and 2. Field 10 gives 3, 4 or 5 for word modes 0, 1 and 2. Writes land at address 0, and reading address 0 returns the 5 control bits.
- R4: A reserved selection gives `clk_src` = 0. The reserved selections are pins 11 in pin mode, and in register mode either field 11 or word mode 3. A reserved selection seen while `bist_en` is high sets a sticky flag, read as bit 0 at address 2. Only reset clears that flag.
- R5: A counted error is `frame_err` high while `bist_en` is high. When no pulse is pending, a counted error drives `pass_o` low for exactly the next cycle.
- R6: Counted errors in back-to-back cycles give separate low pulses, with at least one high cycle between pulses. Up to 15 pulses are queued.
- R7: In the cycle after `bist_en` falls, `pass_o` shows the verdict for 2 cycles: 1 if the count is 0, otherwise 0. Any queued pulses are dropped.
- R8: The count at address 1 goes up by one for each counted error and stops at 255.
- R9: A rising `bist_en` clears the count; an error in that same cycle counts as 1. With `bist_en` low, the count holds and `frame_err` is ignored.
- R10: `pass_o` is 1 whenever neither an error pulse nor a verdict is being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_en | input | 1 | Self-test enable; its rising edge starts a session and its falling edge ends it |
| sel_pins | input | 2 | Strap-pin clock selection used in pin mode |
| frame_err | input | 1 | Errored-frame strobe from the frame checker |
| reg_we | input | 1 | Write strobe for the control register |
| reg_addr | input | 2 | Register address: 0 = control, 1 = count, 2 = flag |
| reg_wdata | input | 5 | Control write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| clk_src | output | 3 | Selected test clock source code |
| pass_o | output | 1 | Live status and end-of-session verdict |

## Verification
Two functions can fall in the same cycle: the end of a session and a burst of error pulses that is still queued. The bench provokes this by lowering `bist_en` right after a run of back-to-back errors, and it expects the verdict to replace the queued pulses at once. A second overlap is the start of a session coinciding with an error strobe. Here the cleared count must come out as 1. A cycle-level reference model judges both cases by comparing `pass_o`, `clk_src` and the read data on every clock.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int CTRL_W = 5;

  localparam logic [2:0] SRC_PCLK = 3'd0;
  localparam logic [2:0] SRC_100  = 3'd1;
  localparam logic [2:0] SRC_75   = 3'd2;
  localparam logic [2:0] SRC_50   = 3'd3;
  localparam logic [2:0] SRC_37P5 = 3'd4;
  localparam logic [2:0] SRC_25   = 3'd5;

  typedef struct packed {
    logic [1:0] wmode;     // [4:3]
    logic [1:0] field;     // [2:1]
    logic       reg_mode;  // [0]
  } ctrl_t;

  // returns {reserved, source code}
  function automatic logic [3:0] decode_src(input ctrl_t c, input logic [1:0] pins);
    logic [3:0] r;
    r = {1'b1, SRC_PCLK};
    if (!c.reg_mode) begin
      case (pins)
        2'b00:   r = {1'b0, SRC_PCLK};
        2'b01:   r = {1'b0, SRC_50};
        2'b10:   r = {1'b0, SRC_25};
        default: r = {1'b1, SRC_PCLK};
      endcase
    end else if (c.wmode == 2'b11 || c.field == 2'b11) begin
      r = {1'b1, SRC_PCLK};
    end else if (c.field == 2'b00) begin
      r = {1'b0, SRC_PCLK};
    end else if (c.field == 2'b01) begin
      case (c.wmode)
        2'd0:    r = {1'b0, SRC_100};
        2'd1:    r = {1'b0, SRC_75};
        default: r = {1'b0, SRC_50};
      endcase
    end else begin
      case (c.wmode)
        2'd0:    r = {1'b0, SRC_50};
        2'd1:    r = {1'b0, SRC_37P5};
        default: r = {1'b0, SRC_25};
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/bist_clksel.sv
module bist_clksel
  import bist_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic [1:0] pins,
  output logic [2:0] src,
  output logic       reserved
);
  logic [3:0] dec;
  assign dec      = decode_src(ctrl, pins);
  assign src      = dec[2:0];
  assign reserved = dec[3];
endmodule

// File: rtl/bist_errcnt.sv
module bist_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= CNT_W'(inc);
    else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bist_pass_seq.sv
module bist_pass_seq #(
  parameter int PEND_W      = 4,
  parameter int VERDICT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic inc,
  input  logic all_clear,
  output logic pass_o,
  output logic verdict_on
);
  localparam int VW = $clog2(VERDICT_CYC + 1);
  localparam logic [PEND_W:0] PMAX = {1'b0, {PEND_W{1'b1}}};

  logic [PEND_W-1:0] pend_q;
  logic              low_q;
  logic [VW-1:0]     vcnt_q;
  logic              vval_q;
  logic [PEND_W:0]   total;

  function automatic logic [PEND_W-1:0] sat(input logic [PEND_W:0] v);
    return (v > PMAX) ? PMAX[PEND_W-1:0] : v[PEND_W-1:0];
  endfunction

  assign total = {1'b0, pend_q} + (PEND_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      low_q  <= 1'b0;
      vcnt_q <= '0;
      vval_q <= 1'b1;
    end else if (stop) begin
      pend_q <= '0;
      low_q  <= 1'b0;
      vcnt_q <= VW'(VERDICT_CYC);
      vval_q <= all_clear;
    end else begin
      if (start)              vcnt_q <= '0;
      else if (vcnt_q != '0)  vcnt_q <= vcnt_q - 1'b1;
      if (low_q) begin
        low_q  <= 1'b0;
        pend_q <= sat(total);
      end else if (total != '0) begin
        low_q  <= 1'b1;
        pend_q <= PEND_W'(total - 1'b1);
      end
    end
  end

  assign verdict_on = (vcnt_q != '0);
  assign pass_o     = verdict_on ? vval_q : ~low_q;
endmodule

// File: rtl/bist_status_ctrl.sv
module bist_status_ctrl
  import bist_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PEND_W      = 4,
  parameter int VERDICT_CYC = 2
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic [1:0]        sel_pins,
  input  logic              frame_err,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [2:0]        clk_src,
  output logic              pass_o
);
  ctrl_t            ctrl_q;
  logic             en_q;
  logic             cfg_err;
  logic             cfg_reserved;
  logic             sess_start;
  logic             sess_stop;
  logic             err_hit;
  logic             verdict_on;
  logic [CNT_W-1:0] err_cnt;

  assign sess_start = bist_en & ~en_q;
  assign sess_stop  = ~bist_en & en_q;
  assign err_hit    = frame_err & bist_en;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      en_q    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      en_q <= bist_en;
      if (reg_we && reg_addr == 2'd0) ctrl_q <= ctrl_t'(reg_wdata);
      if (bist_en && cfg_reserved)    cfg_err <= 1'b1;
    end
  end

  bist_clksel u_sel (
    .ctrl     (ctrl_q),
    .pins     (sel_pins),
    .src      (clk_src),
    .reserved (cfg_reserved)
  );

  bist_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk2x),
    .rst_n (rst_n),
    .start (sess_start),
    .inc   (err_hit),
    .cnt   (err_cnt)
  );

  bist_pass_seq #(.PEND_W(PEND_W), .VERDICT_CYC(VERDICT_CYC)) u_seq (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .start      (sess_start),
    .stop       (sess_stop),
    .inc        (err_hit),
    .all_clear  (err_cnt == '0),
    .pass_o     (pass_o),
    .verdict_on (verdict_on)
  );

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = CNT_W'(ctrl_q);
      2'd1:    reg_rdata = err_cnt;
      2'd2:    reg_rdata = CNT_W'(cfg_err);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bist_status_chk.sv
module bist_status_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk2x,
  input logic             rst_n,
  input logic             bist_en,
  input logic             pass_o,
  input logic             sess_start,
  input logic             sess_stop,
  input logic             verdict_on,
  input logic             cfg_err,
  input logic             cfg_reserved,
  input logic [CNT_W-1:0] err_cnt,
  input logic [2:0]       clk_src
);
  AST_PULSE_GAP: assert property (@(posedge clk2x) disable iff (!rst_n)
    (!pass_o && !verdict_on) |=> (pass_o || verdict_on)); // R6

  AST_NO_WRAP: assert property (@(posedge clk2x) disable iff (!rst_n)
    (err_cnt == {CNT_W{1'b1}} && !sess_start) |=> (err_cnt == {CNT_W{1'b1}})); // R8

  AST_START_CLEARS: assert property (@(posedge clk2x) disable iff (!rst_n)
    sess_start |=> (err_cnt <= CNT_W'(1))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk2x) disable iff (!rst_n)
    !bist_en |=> $stable(err_cnt)); // R9

  AST_VERDICT: assert property (@(posedge clk2x) disable iff (!rst_n)
    sess_stop |=> (pass_o == $past(err_cnt == '0))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk2x) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R4

  AST_RSVD_PCLK: assert property (@(posedge clk2x) disable iff (!rst_n)
    cfg_reserved |-> (clk_src == 3'd0)); // R4

  AST_IDLE_HIGH: assert property (@(posedge clk2x) disable iff (!rst_n)
    (!bist_en && !sess_stop && !verdict_on) |-> pass_o); // R10
endmodule

bind bist_status_ctrl bist_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk2x        (clk2x),
  .rst_n        (rst_n),
  .bist_en      (bist_en),
  .pass_o       (pass_o),
  .sess_start   (sess_start),
  .sess_stop    (sess_stop),
  .verdict_on   (verdict_on),
  .cfg_err      (cfg_err),
  .cfg_reserved (cfg_reserved),
  .err_cnt      (err_cnt),
  .clk_src      (clk_src)
);

// File: tb/tb_bist_status_ctrl.sv
module tb_bist_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_en = 1'b0;
  logic [1:0] sel_pins = 2'b00;
  logic       frame_err = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic [4:0] reg_wdata = 5'd0;
  logic [7:0] reg_rdata;
  logic [2:0] clk_src;
  logic       pass_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  bist_status_ctrl dut (
    .clk2x(clk2x), .rst_n(rst_n), .bist_en(bist_en), .sel_pins(sel_pins),
    .frame_err(frame_err), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_src(clk_src),
    .pass_o(pass_o)
  );

  // ---------------- reference model ----------------
  int m_ctrl, m_cnt, m_cfg, m_pend, m_vleft;
  bit m_low, m_vval, m_en;

  function automatic int exp_src(int ctrl, int pins, output bit rsvd);
    int f, w;
    rsvd = 0;
    f = (ctrl >> 1) & 3;
    w = (ctrl >> 3) & 3;
    if ((ctrl & 1) == 0) begin
      if (pins == 1) return 3;
      if (pins == 2) return 5;
      if (pins == 3) rsvd = 1;
      return 0;
    end
    if (f == 3 || w == 3) begin rsvd = 1; return 0; end
    if (f == 0) return 0;
    if (f == 1) return w + 1;
    return w + 3;
  endfunction

  always @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_cfg = 0; m_pend = 0; m_vleft = 0;
      m_low = 0; m_vval = 1; m_en = 0;
    end else begin
      bit q, st, sp, rs;
      int tot, dummy;
      q  = frame_err && bist_en;
      st = bist_en && !m_en;
      sp = !bist_en && m_en;
      dummy = exp_src(m_ctrl, int'(sel_pins), rs);
      if (bist_en && rs) m_cfg = 1;
      if (sp) begin
        m_vval = (m_cnt == 0); m_vleft = 2; m_pend = 0; m_low = 0;
      end else begin
        if (st) m_vleft = 0; else if (m_vleft > 0) m_vleft--;
        tot = m_pend + (q ? 1 : 0);
        if (m_low) begin m_low = 0; m_pend = (tot > 15) ? 15 : tot; end
        else if (tot > 0) begin m_low = 1; m_pend = tot - 1; end
      end
      if (st) m_cnt = q ? 1 : 0;
      else if (q && m_cnt < 255) m_cnt++;
      if (reg_we && reg_addr == 2'd0) m_ctrl = int'(reg_wdata);
      m_en = bist_en;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    bit rs;
    int es, er;
    @(negedge clk2x);
    es = exp_src(m_ctrl, int'(sel_pins), rs);
    cmp("R5 R6 R7 R10 pass_o", int'(pass_o), (m_vleft > 0) ? int'(m_vval) : int'(!m_low));
    cmp("R2 R3 R4 clk_src", int'(clk_src), es);
    case (reg_addr)
      2'd0: er = m_ctrl;
      2'd1: er = m_cnt;
      2'd2: er = m_cfg;
      default: er = 0;
    endcase
    cmp((reg_addr == 2'd0) ? "R3 rdata" : (reg_addr == 2'd2) ? "R4 rdata" : "R8 R9 rdata",
        int'(reg_rdata), er);
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    cmp("R1 pass", int'(pass_o), 1);
    cmp("R1 count", int'(reg_rdata), 0);
    reg_addr = 2'd2; tick();
    cmp("R1 flag", int'(reg_rdata), 0);
    reg_addr = 2'd0; tick();
    cmp("R1 ctrl", int'(reg_rdata), 0);

    // pin mode sweep, test idle: reserved must not set flag
    reg_addr = 2'd2;
    for (int p = 0; p < 4; p++) begin sel_pins = 2'(p); tick(); end
    cmp("R4 idle no flag", int'(reg_rdata), 0);

    // register mode sweep
    reg_addr = 2'd0;
    for (int w = 0; w < 4; w++)
      for (int f = 0; f < 4; f++) begin
        reg_we = 1'b1; reg_wdata = 5'((w << 3) | (f << 1) | 1); tick();
        reg_we = 1'b0; tick();
      end
    reg_we = 1'b1; reg_wdata = 5'b01011; tick(); // wmode1 field01
    reg_we = 1'b0; tick();
    cmp("R3 75MHz", int'(clk_src), 2);
    reg_we = 1'b1; reg_wdata = 5'd0; tick();
    reg_we = 1'b0; sel_pins = 2'b01; tick();
    cmp("R2 50MHz", int'(clk_src), 3);

    // clean session
    reg_addr = 2'd1;
    bist_en = 1'b1; repeat (5) tick();
    bist_en = 1'b0; tick();
    cmp("R7 clean verdict", int'(pass_o), 1); tick();
    cmp("R7 clean verdict 2", int'(pass_o), 1); tick();

    // errored session: strobe on start, single, burst, stop with queue
    bist_en = 1'b1; frame_err = 1'b1; tick();
    cmp("R5 pulse low", int'(pass_o), 0);
    frame_err = 1'b0; repeat (3) tick();
    frame_err = 1'b1; repeat (4) tick();
    frame_err = 1'b0; tick();
    frame_err = 1'b1; tick();
    frame_err = 1'b0; bist_en = 1'b0; tick();
    cmp("R7 fail verdict", int'(pass_o), 0); tick();
    cmp("R7 fail verdict 2", int'(pass_o), 0); tick();
    cmp("R10 idle high", int'(pass_o), 1);
    cmp("R8 count 6", int'(reg_rdata), 6);
    frame_err = 1'b1; repeat (3) tick();
    frame_err = 1'b0; tick();
    cmp("R9 held idle", int'(reg_rdata), 6);
    cmp("R9 idle pass", int'(pass_o), 1);

    // saturation
    bist_en = 1'b1; frame_err = 1'b1; repeat (300) tick();
    frame_err = 1'b0; tick();
    cmp("R8 saturate", int'(reg_rdata), 255);
    bist_en = 1'b0; repeat (3) tick();
    bist_en = 1'b1; tick();
    cmp("R9 restart clears", int'(reg_rdata), 0);
    bist_en = 1'b0; repeat (3) tick();

    // reserved during session
    sel_pins = 2'b11; bist_en = 1'b1; reg_addr = 2'd2; tick();
    cmp("R4 flag set", int'(reg_rdata), 1);
    cmp("R4 pclk fallback", int'(clk_src), 0);
    sel_pins = 2'b00; bist_en = 1'b0; repeat (4) tick();
    cmp("R4 flag sticky", int'(reg_rdata), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule